// File: doc/BRIEF.md
# Codec Host Bus and DMA Interface

This block connects an audio codec core to an 8-bit asynchronous host bus. The host reaches four direct registers through programmed I/O (PIO) cycles qualified by chip select. Sample data moves through two small FIFOs using a request/acknowledge handshake in each direction. On the capture side, the core fills the FIFO and the host drains it with DMA reads. On the playback side, the host fills the FIFO with DMA writes and the core drains it. The block also drives the enable and direction pins of an external data bus transceiver.

All host strobes, selects, acknowledges, the address and the write data are brought into the internal clock through a two-stage register chain. A cycle controller classifies each host cycle when the synchronized strobe becomes active. It commits the cycle's single side effect when the synchronized strobe goes away: a register write, a FIFO push, a FIFO pop, or setting the error flag.

The controller states are:
- IDLE: waits for a strobe.
- PIO_RD and PIO_WR: register cycles.
- DMA_RD and DMA_WR: sample cycles.
- ACK_ERR: both acknowledges were seen together.
- SKIP: an unqualified cycle that is ignored.

Every active state returns to IDLE on the strobe-release transition, and that transition is where the commit happens. From IDLE, the controller checks conditions in this order and takes the first that matches:
1. Both acknowledges are asserted: go to ACK_ERR.
2. Capture acknowledge with a read strobe: go to DMA_RD.
3. Playback acknowledge with a write strobe: go to DMA_WR.
4. Any other acknowledge combination: go to SKIP.
5. Chip select with a read strobe: go to PIO_RD.
6. Chip select with a write strobe: go to PIO_WR.
7. Anything else: go to SKIP.

Top module: `codec_hostbus`

## Requirements
- R1: `cap_req` is high exactly when the capture FIFO holds at least one entry. It is low after reset.
- R2: `play_req` is high exactly when the playback FIFO is not full (default depth 4). It is high after reset.
- R3: A DMA read (capture acknowledge low during read strobe low) drives the oldest capture entry on `bus_out`. It removes that entry exactly once, when the strobe is released.
- R4: A DMA write (playback acknowledge low during write strobe low) stores the `bus_in` value in the playback FIFO exactly once. Entries come out in order.
- R5: With no acknowledge asserted, a strobe without chip select low has no effect: registers are unchanged and `bus_out` is not driven.
- R6: The address picks the PIO register. Addresses 0, 1 and 3 are read/write 8-bit scratch registers. Address 2 is status, read as {5'b0, playback full (bit 2), capture empty (bit 1), error (bit 0)}. Writing to address 2 with bit 0 set clears the error flag, and no other status bit is writable.
- R7: DMA cycles work whether chip select is high or low.
- R8: `xcvr_en_n` is low exactly when a strobe is low together with chip select or either acknowledge. Otherwise it is high.
- R9: `xcvr_dir` is low exactly when the read strobe is low together with chip select or either acknowledge. Otherwise it is high.
- R10: A cycle with both acknowledges low changes neither FIFO and sets the sticky error flag.
- R11: A DMA read of an empty capture FIFO returns 0 and leaves it empty. A DMA write to a full playback FIFO is dropped.
- R12: `bus_oe` is high only during a qualified PIO or DMA read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select for register cycles, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| cap_ack_n | input | 1 | Capture DMA acknowledge, active low |
| play_ack_n | input | 1 | Playback DMA acknowledge, active low |
| addr | input | 2 | Direct register select |
| bus_in | input | 8 | Data from host bus |
| bus_out | output | 8 | Data toward host bus |
| bus_oe | output | 1 | Drive enable for `bus_out` |
| xcvr_en_n | output | 1 | External transceiver enable, active low |
| xcvr_dir | output | 1 | Transceiver direction, high = host to block |
| cap_req | output | 1 | Capture data request |
| play_req | output | 1 | Playback data request |
| cap_push | input | 1 | Core-side capture FIFO write |
| cap_wdata | input | 8 | Core-side capture sample |
| cap_full | output | 1 | Capture FIFO full |
| play_pop | input | 1 | Core-side playback FIFO read |
| play_rdata | output | 8 | Oldest playback entry |
| play_empty | output | 1 | Playback FIFO empty |

## Verification
The error-flag property assumes that the core-side port does not pop the playback FIFO in the same cycle that an acknowledge-collision cycle commits. The bench keeps its stub port idle whenever a host cycle is open.

The transceiver properties take the host pins as fully asynchronous and need no assumption. The bench holds the address, data, select and acknowledge pins steady for the whole strobe plus four clocks, well beyond the two-stage synchronizer delay. This lets every classification and commit be observed unambiguously.

// File: rtl/codec_hostbus_pkg.sv
package codec_hostbus_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PIO_RD,
        ST_PIO_WR,
        ST_DMA_RD,
        ST_DMA_WR,
        ST_ACK_ERR,
        ST_SKIP
    } cyc_state_t;

    localparam logic [1:0] ADDR_STATUS = 2'd2;

endpackage

// File: rtl/codec_sync.sv
module codec_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/codec_fifo.sv
module codec_fifo #(
    parameter int DW    = 8,
    parameter int DEPTH = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic [DW-1:0]                wdata,
    input  logic                         pop,
    output logic [DW-1:0]                head,
    output logic                         full,
    output logic                         empty,
    output logic [$clog2(DEPTH+1)-1:0]   count
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH+1);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic          do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rptr];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_push) wptr <= bump(wptr);
            if (do_pop)  rptr <= bump(rptr);
            unique case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/codec_hostbus.sv
module codec_hostbus #(
    parameter int DW          = 8,
    parameter int FIFO_DEPTH  = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          rd_n,
    input  logic          wr_n,
    input  logic          cap_ack_n,
    input  logic          play_ack_n,
    input  logic [1:0]    addr,
    input  logic [DW-1:0] bus_in,
    output logic [DW-1:0] bus_out,
    output logic          bus_oe,
    output logic          xcvr_en_n,
    output logic          xcvr_dir,
    output logic          cap_req,
    output logic          play_req,
    input  logic          cap_push,
    input  logic [DW-1:0] cap_wdata,
    output logic          cap_full,
    input  logic          play_pop,
    output logic [DW-1:0] play_rdata,
    output logic          play_empty
);
    import codec_hostbus_pkg::*;

    localparam int CW = $clog2(FIFO_DEPTH+1);

    // synchronized active-high controls
    logic [4:0]      ctrl_s;
    logic            s_rd, s_wr, s_cs, s_cack, s_pack, s_strb;
    logic [DW+1:0]   dat_s;
    logic [1:0]      s_addr;
    logic [DW-1:0]   s_bus;

    codec_sync #(.W(5), .STAGES(SYNC_STAGES)) u_ctrl_sync (
        .clk (clk),
        .rst_n (rst_n),
        .d   ({~rd_n, ~wr_n, ~cs_n, ~cap_ack_n, ~play_ack_n}),
        .q   (ctrl_s)
    );

    codec_sync #(.W(DW+2), .STAGES(SYNC_STAGES)) u_data_sync (
        .clk (clk),
        .rst_n (rst_n),
        .d   ({addr, bus_in}),
        .q   (dat_s)
    );

    assign {s_rd, s_wr, s_cs, s_cack, s_pack} = ctrl_s;
    assign {s_addr, s_bus} = dat_s;
    assign s_strb = s_rd | s_wr;

    // FIFOs
    logic [DW-1:0] cap_head;
    logic          cap_empty, play_full;
    logic [CW-1:0] cap_cnt, play_cnt;
    logic          cap_pop, play_push;
    logic [DW-1:0] wr_hold;

    codec_fifo #(.DW(DW), .DEPTH(FIFO_DEPTH)) u_cap_fifo (
        .clk (clk), .rst_n (rst_n),
        .push (cap_push), .wdata (cap_wdata),
        .pop (cap_pop), .head (cap_head),
        .full (cap_full), .empty (cap_empty), .count (cap_cnt)
    );

    codec_fifo #(.DW(DW), .DEPTH(FIFO_DEPTH)) u_play_fifo (
        .clk (clk), .rst_n (rst_n),
        .push (play_push), .wdata (wr_hold),
        .pop (play_pop), .head (play_rdata),
        .full (play_full), .empty (play_empty), .count (play_cnt)
    );

    assign cap_req  = !cap_empty;
    assign play_req = !play_full;

    // transceiver controls straight from the pins
    logic pin_qual;
    assign pin_qual  = !cs_n || !cap_ack_n || !play_ack_n;
    assign xcvr_en_n = !((!rd_n || !wr_n) && pin_qual);
    assign xcvr_dir  = !(!rd_n && pin_qual);

    // cycle controller
    cyc_state_t state, state_nx;
    logic       leaving;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (s_strb) begin
                    if (s_cack && s_pack)      state_nx = ST_ACK_ERR;
                    else if (s_cack && s_rd)   state_nx = ST_DMA_RD;
                    else if (s_pack && s_wr)   state_nx = ST_DMA_WR;
                    else if (s_cack || s_pack) state_nx = ST_SKIP;
                    else if (s_cs && s_rd)     state_nx = ST_PIO_RD;
                    else if (s_cs && s_wr)     state_nx = ST_PIO_WR;
                    else                       state_nx = ST_SKIP;
                end
            end
            ST_PIO_RD, ST_PIO_WR, ST_DMA_RD, ST_DMA_WR, ST_ACK_ERR, ST_SKIP: begin
                if (!s_strb) state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // registers
    logic [DW-1:0] reg_a, reg_b, reg_c;
    logic [1:0]    addr_hold;
    logic          err_flag;
    logic [DW-1:0] status_word;

    assign status_word = {{(DW-3){1'b0}}, play_full, cap_empty, err_flag};

    // outputs
    always_comb begin
        leaving   = (state != ST_IDLE) && !s_strb;
        cap_pop   = leaving && (state == ST_DMA_RD);
        play_push = leaving && (state == ST_DMA_WR);
        bus_oe    = 1'b0;
        bus_out   = '0;
        unique case (state)
            ST_PIO_RD: begin
                bus_oe = 1'b1;
                unique case (addr_hold)
                    2'd0:        bus_out = reg_a;
                    2'd1:        bus_out = reg_b;
                    ADDR_STATUS: bus_out = status_word;
                    default:     bus_out = reg_c;
                endcase
            end
            ST_DMA_RD: begin
                bus_oe  = 1'b1;
                bus_out = cap_empty ? '0 : cap_head;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_hold <= '0;
            wr_hold   <= '0;
            reg_a     <= '0;
            reg_b     <= '0;
            reg_c     <= '0;
            err_flag  <= 1'b0;
        end else begin
            if (state == ST_IDLE && s_strb) addr_hold <= s_addr;
            if ((state == ST_PIO_WR || state == ST_DMA_WR) && s_strb) wr_hold <= s_bus;
            if (leaving && state == ST_PIO_WR) begin
                unique case (addr_hold)
                    2'd0:        reg_a <= wr_hold;
                    2'd1:        reg_b <= wr_hold;
                    ADDR_STATUS: if (wr_hold[0]) err_flag <= 1'b0;
                    default:     reg_c <= wr_hold;
                endcase
            end
            if (leaving && state == ST_ACK_ERR) err_flag <= 1'b1;
        end
    end
endmodule

// File: rtl/codec_hostbus_chk.sv
module codec_hostbus_chk #(
    parameter int DEPTH = 4,
    parameter int CW    = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rd_n,
    input logic          wr_n,
    input logic          xcvr_en_n,
    input logic          xcvr_dir,
    input logic          cap_req,
    input logic          play_req,
    input logic [CW-1:0] cap_cnt,
    input logic [CW-1:0] play_cnt,
    input logic          err_flag
);
    p_cap_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cap_req == (cap_cnt != '0));

    p_play_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        play_req == (play_cnt != CW'(DEPTH)));

    p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_cnt <= CW'(DEPTH)) && (play_cnt <= CW'(DEPTH)));

    p_idle_xcvr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_n && wr_n) |-> (xcvr_en_n && xcvr_dir));

    p_dir_needs_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !xcvr_dir |-> !xcvr_en_n);

    p_err_keeps_fifo_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_flag) |-> $stable(play_cnt));
endmodule

bind codec_hostbus codec_hostbus_chk #(.DEPTH(FIFO_DEPTH), .CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .xcvr_en_n (xcvr_en_n),
    .xcvr_dir  (xcvr_dir),
    .cap_req   (cap_req),
    .play_req  (play_req),
    .cap_cnt   (cap_cnt),
    .play_cnt  (play_cnt),
    .err_flag  (err_flag)
);

// File: tb/codec_hostbus_test.sv
module codec_hostbus_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 0;
    logic       rst_n, cs_n, rd_n, wr_n, cap_ack_n, play_ack_n;
    logic [1:0] addr;
    logic [7:0] bus_in, bus_out, cap_wdata, play_rdata;
    logic       bus_oe, xcvr_en_n, xcvr_dir, cap_req, play_req;
    logic       cap_push, cap_full, play_pop, play_empty;

    always #(CLK_PERIOD/2) clk = ~clk;

    codec_hostbus uut (
        .clk (clk), .rst_n (rst_n), .cs_n (cs_n), .rd_n (rd_n), .wr_n (wr_n),
        .cap_ack_n (cap_ack_n), .play_ack_n (play_ack_n), .addr (addr),
        .bus_in (bus_in), .bus_out (bus_out), .bus_oe (bus_oe),
        .xcvr_en_n (xcvr_en_n), .xcvr_dir (xcvr_dir),
        .cap_req (cap_req), .play_req (play_req),
        .cap_push (cap_push), .cap_wdata (cap_wdata), .cap_full (cap_full),
        .play_pop (play_pop), .play_rdata (play_rdata), .play_empty (play_empty)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    logic [7:0] exp_q[$];
    logic [7:0] got_q[$];
    string      tag_q[$];

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        while (exp_q.size() > 0 && got_q.size() > 0) begin
            automatic logic [7:0] e = exp_q.pop_front();
            automatic logic [7:0] g = got_q.pop_front();
            automatic string      t = tag_q.pop_front();
            chk(g === e, t, g, e);
        end
    end

    task automatic idle_pins();
        cs_n = 1; rd_n = 1; wr_n = 1; cap_ack_n = 1; play_ack_n = 1;
    endtask

    task automatic bus_cycle(input bit rd, input bit cs, input bit ca, input bit pa,
                             input logic [1:0] a, input logic [7:0] d,
                             input bit drive, input logic [7:0] expv, input string tag);
        bit qual;
        @(negedge clk);
        cs_n = !cs; cap_ack_n = !ca; play_ack_n = !pa; addr = a; bus_in = d;
        rd_n = !rd; wr_n = rd;
        repeat (4) @(negedge clk);
        qual = cs || ca || pa;
        chk(xcvr_en_n == !qual, "R8 xcvr_en_n", xcvr_en_n, !qual);
        chk(xcvr_dir == !(rd && qual), "R9 xcvr_dir", xcvr_dir, !(rd && qual));
        chk(bus_oe == drive, {"R12 bus_oe ", tag}, bus_oe, drive);
        if (drive) begin
            exp_q.push_back(expv);
            tag_q.push_back(tag);
            got_q.push_back(bus_out);
        end
        idle_pins();
        repeat (4) @(negedge clk);
    endtask

    task automatic stub_push(input logic [7:0] v);
        @(negedge clk);
        cap_push = 1; cap_wdata = v;
        @(negedge clk);
        cap_push = 0;
    endtask

    task automatic stub_pop(input logic [7:0] expv);
        @(negedge clk);
        chk(!play_empty, "R4 entry present", play_empty, 0);
        exp_q.push_back(expv);
        tag_q.push_back("R4 playback order");
        got_q.push_back(play_rdata);
        play_pop = 1;
        @(negedge clk);
        play_pop = 0;
    endtask

    initial begin
        rst_n = 0; idle_pins(); addr = 0; bus_in = 0;
        cap_push = 0; cap_wdata = 0; play_pop = 0;
        repeat (5) @(negedge clk);
        rst_n = 1;
        repeat (2) @(negedge clk);
        chk(cap_req == 0, "R1 reset cap_req", cap_req, 0);
        chk(play_req == 1, "R2 reset play_req", play_req, 1);
        chk(xcvr_en_n == 1 && xcvr_dir == 1, "R8 R9 reset xcvr", {xcvr_en_n, xcvr_dir}, 3);
        chk(bus_oe == 0, "R12 reset bus_oe", bus_oe, 0);

        // PIO registers
        bus_cycle(0, 1, 0, 0, 2'd0, 8'h5A, 0, 0, "R6");
        bus_cycle(0, 1, 0, 0, 2'd1, 8'hC3, 0, 0, "R6");
        bus_cycle(0, 1, 0, 0, 2'd3, 8'h81, 0, 0, "R6");
        bus_cycle(1, 1, 0, 0, 2'd0, 0, 1, 8'h5A, "R6 reg0");
        bus_cycle(1, 1, 0, 0, 2'd1, 0, 1, 8'hC3, "R6 reg1");
        bus_cycle(1, 1, 0, 0, 2'd3, 0, 1, 8'h81, "R6 reg3");
        bus_cycle(1, 1, 0, 0, 2'd2, 0, 1, 8'h02, "R6 status idle");

        // no chip select
        bus_cycle(0, 0, 0, 0, 2'd0, 8'hFF, 0, 0, "R5 write ignored");
        bus_cycle(1, 0, 0, 0, 2'd0, 0, 0, 0, "R5 read not driven");
        bus_cycle(1, 1, 0, 0, 2'd0, 0, 1, 8'h5A, "R5 reg0 kept");

        // capture DMA
        stub_push(8'h11); stub_push(8'h22); stub_push(8'h33);
        @(negedge clk);
        chk(cap_req == 1, "R1 cap_req with data", cap_req, 1);
        bus_cycle(1, 0, 1, 0, 2'd0, 0, 1, 8'h11, "R3 R7 cs high");
        bus_cycle(1, 1, 1, 0, 2'd1, 0, 1, 8'h22, "R7 cs low");
        bus_cycle(1, 0, 1, 0, 2'd0, 0, 1, 8'h33, "R3 third");
        chk(cap_req == 0, "R1 cap_req drained", cap_req, 0);
        bus_cycle(1, 0, 1, 0, 2'd0, 0, 1, 8'h00, "R11 empty read");
        chk(cap_req == 0, "R11 still empty", cap_req, 0);

        // playback DMA
        for (int i = 0; i < 4; i++)
            bus_cycle(0, 0, 0, 1, 2'd0, 8'hA0 + 8'(i), 0, 0, "R4");
        chk(play_req == 0, "R2 full", play_req, 0);
        bus_cycle(0, 0, 0, 1, 2'd0, 8'hEE, 0, 0, "R11 dropped");
        bus_cycle(1, 1, 0, 0, 2'd2, 0, 1, 8'h06, "R6 status full");
        for (int i = 0; i < 4; i++) stub_pop(8'hA0 + 8'(i));
        @(negedge clk);
        chk(play_empty == 1, "R11 extra write dropped", play_empty, 1);
        chk(play_req == 1, "R2 not full", play_req, 1);

        // acknowledge collision
        bus_cycle(0, 0, 1, 1, 2'd0, 8'h77, 0, 0, "R10 write");
        chk(play_empty == 1, "R10 playback unchanged", play_empty, 1);
        stub_push(8'h44);
        bus_cycle(1, 0, 1, 1, 2'd0, 0, 0, 0, "R10 read");
        chk(cap_req == 1, "R10 capture unchanged", cap_req, 1);
        bus_cycle(1, 1, 0, 0, 2'd2, 0, 1, 8'h01, "R10 sticky error");
        bus_cycle(0, 1, 0, 0, 2'd2, 8'h01, 0, 0, "R6 clear");
        bus_cycle(1, 1, 0, 0, 2'd2, 0, 1, 8'h00, "R6 error cleared");
        bus_cycle(1, 0, 1, 0, 2'd0, 0, 1, 8'h44, "R3 after error");

        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule